// File: doc/BRIEF.md
# Vectored Interrupt Controller, 32 Lines

This block gathers 32 external request lines into one prioritised interrupt request for a processor core. A rising edge on a line marks that line pending. Software can also force a line pending or withdraw it. Each line has its own enable bit and a 2-bit priority. Each cycle the controller picks one winner from the lines that are both pending and enabled. It reports the winner as a vector number, which is the line index plus 16, and raises a flag while any such line exists.

Software reaches the state through a simple word port. Writes are single-cycle strobes and reads are combinational. Enable state and pending state each have a write-one-to-set address and a write-one-to-clear address. Either address of a pair reads back the same mask. When the core takes an interrupt, it returns the vector on the acknowledge input. That clears the matching pending bit at the same clock edge.

Top module: `vic32_core`

## Requirements
- R1: A write to address 0x100 enables every line whose data bit is 1 and leaves lines with a 0 bit unchanged. A read of 0x100 returns the enable mask, with bit n for line n.
- R2: A write to address 0x180 disables every line whose data bit is 1 and leaves the others unchanged. A read of 0x180 also returns the enable mask.
- R3: A write of 1 to bit n at 0x200 makes line n pending, and a write of 1 to bit n at 0x280 makes it not pending. Zero bits have no effect. Both addresses read back the pending mask.
- R4: The priority of line 4k+j is held at word address 0x400+4k in bits [8j+7:8j+6]. The other bits of each priority word read as 0 and ignore writes.
- R5: Among the candidate lines, the one with the numerically smallest priority wins, where 0 is the most urgent and 3 the least.
- R6: When candidates share the best priority, the lowest line number wins.
- R7: Only lines that are both pending and enabled are candidates. The reported vector is the winner's line number plus 16, with the any-pending flag high. With no candidate, the vector is 0 and the flag is low.
- R8: A 0-to-1 transition on a request line sets its pending bit at the next clock edge. A line held high does not set the bit again after it has been cleared.
- R9: An acknowledge carrying vector n+16 clears line n's pending bit at that clock edge, and an acknowledge for any other vector leaves line n's bit unchanged. If a set source (edge or 0x200 write) hits the same line in the same cycle, the bit stays set.
- R10: After reset the enable mask, the pending mask and all priorities are 0, and the vector output is 0 with the flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Request lines, rising-edge sensitive |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 12 | Byte address of the accessed word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| ack_valid | input | 1 | Core acknowledges an interrupt this cycle |
| ack_vec | input | 9 | Vector number being acknowledged |
| top_vec | output | 9 | Winning vector number, 0 when none |
| top_any | output | 1 | High while some line is pending and enabled |

## Verification
Any wrong enable, pending or priority bit becomes visible at the ports one cycle after the edge that stored it. It shows up as a changed vector, or a dropped flag, as soon as the corrupted line is a candidate. The same state reads back directly at the register addresses. The checks therefore aim at arbitration outcomes that a single wrong bit would flip. These include equal-priority ties, an urgent high-numbered line beating a lax low-numbered one, and enable gating of a pending line. They also cover the edge cases where a set and a clear land in the same cycle.

// File: rtl/vic32_core.sv
module vic32_core #(
  parameter int N_IRQ    = 32,
  parameter int PRIO_W   = 2,
  parameter int ADDR_W   = 12,
  parameter int VEC_W    = 9,
  parameter int VEC_BASE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       irq_in,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              ack_valid,
  input  logic [VEC_W-1:0]  ack_vec,
  output logic [VEC_W-1:0]  top_vec,
  output logic              top_any
);
  localparam int IDX_W = $clog2(N_IRQ);
  localparam int WORDS = N_IRQ / 4;
  localparam int WI_W  = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] A_SETEN = ADDR_W'(12'h100);
  localparam logic [ADDR_W-1:0] A_CLREN = ADDR_W'(12'h180);
  localparam logic [ADDR_W-1:0] A_SETP  = ADDR_W'(12'h200);
  localparam logic [ADDR_W-1:0] A_CLRP  = ADDR_W'(12'h280);
  localparam logic [ADDR_W-1:0] A_PRIO  = ADDR_W'(12'h400);

  logic [N_IRQ-1:0]  en_q, pend_q, irq_q;
  logic [PRIO_W-1:0] prio_q [N_IRQ];

  logic [N_IRQ-1:0] wmask, rise, ack_mask, set_mask, clr_mask, cand;
  logic [WI_W-1:0]  word_idx;
  logic             prio_sel;

  assign wmask    = reg_wdata[N_IRQ-1:0];
  assign rise     = irq_in[N_IRQ-1:0] & ~irq_q;
  assign word_idx = reg_addr[ADDR_W-1:2] - A_PRIO[ADDR_W-1:2];
  assign prio_sel = (reg_addr >= A_PRIO) && (word_idx < WI_W'(WORDS)) && (reg_addr[1:0] == 2'b00);

  always_comb begin
    ack_mask = '0;
    for (int i = 0; i < N_IRQ; i++)
      ack_mask[i] = ack_valid && (ack_vec == VEC_W'(i + VEC_BASE));
  end

  assign set_mask = rise | ((reg_we && reg_addr == A_SETP) ? wmask : '0);
  assign clr_mask = ack_mask | ((reg_we && reg_addr == A_CLRP) ? wmask : '0);
  assign cand     = pend_q & en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
      irq_q  <= '0;
    end else begin
      irq_q  <= irq_in[N_IRQ-1:0];
      pend_q <= (pend_q & ~clr_mask) | set_mask;
      if (reg_we && reg_addr == A_SETEN) en_q <= en_q | wmask;
      if (reg_we && reg_addr == A_CLREN) en_q <= en_q & ~wmask;
    end
  end

  for (genvar g = 0; g < N_IRQ; g++) begin : g_prio
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        prio_q[g] <= '0;
      else if (reg_we && prio_sel && word_idx == WI_W'(g / 4))
        prio_q[g] <= reg_wdata[8*(g%4)+7 -: PRIO_W];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_SETEN || reg_addr == A_CLREN)
      reg_rdata[N_IRQ-1:0] = en_q;
    else if (reg_addr == A_SETP || reg_addr == A_CLRP)
      reg_rdata[N_IRQ-1:0] = pend_q;
    else if (prio_sel)
      for (int i = 0; i < N_IRQ; i++)
        if (word_idx == WI_W'(i / 4))
          reg_rdata[8*(i%4)+7 -: PRIO_W] = prio_q[i];
  end

  logic [IDX_W-1:0]  best_idx;
  logic [PRIO_W-1:0] best_p;
  logic              found;

  always_comb begin
    best_idx = '0;
    best_p   = '1;
    found    = 1'b0;
    for (int i = N_IRQ - 1; i >= 0; i--)
      if (cand[i] && (!found || prio_q[i] <= best_p)) begin
        found    = 1'b1;
        best_p   = prio_q[i];
        best_idx = IDX_W'(i);
      end
  end

  assign top_any = found;
  assign top_vec = found ? VEC_W'(best_idx) + VEC_W'(VEC_BASE) : '0;

  AST_SETEN_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_SETEN) |=> ((en_q & $past(wmask)) == $past(wmask))); // R1
  AST_CLREN_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_CLREN) |=> ((en_q & $past(wmask)) == '0)); // R2
  AST_CLRP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_CLRP && (rise & wmask) == '0) |=> ((pend_q & $past(wmask)) == '0)); // R3
  AST_WINNER_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    top_any |-> (cand[IDX_W'(top_vec - VEC_W'(VEC_BASE))] && top_vec >= VEC_W'(VEC_BASE))); // R7
  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((pend_q & $past(rise)) == $past(rise))); // R8
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && top_any && ack_vec == top_vec && !(reg_we && reg_addr == A_SETP) && rise == '0)
    |=> !pend_q[$past(best_idx)]); // R9
endmodule

// File: tb/test_vic32_core.sv
module test_vic32_core;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] irq_in = '0;
  logic        reg_we = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ack_valid = 0;
  logic [8:0]  ack_vec = '0;
  logic [8:0]  top_vec;
  logic        top_any;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  vic32_core i_vic32_core (.clk, .rst_n, .irq_in, .reg_we, .reg_addr, .reg_wdata,
    .reg_rdata, .ack_valid, .ack_vec, .top_vec, .top_any);

  // {priority word 0, pending mask, expected vector}
  localparam logic [72:0] TBL [6] = '{
    {32'h0000_0000, 32'h0000_0000, 9'd0},
    {32'h0000_0000, 32'h0000_0001, 9'd16},
    {32'h0000_0000, 32'h0000_000C, 9'd18},
    {32'hC040_80C0, 32'h0000_000B, 9'd17},
    {32'hC040_80C0, 32'h0000_0009, 9'd16},
    {32'h00C0_C0C0, 32'h0000_000F, 9'd19}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0; #1;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic ack(input logic [8:0] v);
    @(negedge clk); ack_valid = 1; ack_vec = v;
    @(negedge clk); ack_valid = 0; #1;
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    chk("R10 vec", {23'd0, top_vec}, 0);
    chk("R10 any", {31'd0, top_any}, 0);
    rd(12'h100, d); chk("R10 en", d, 0);
    rd(12'h200, d); chk("R10 pend", d, 0);
    rd(12'h41C, d); chk("R10 prio", d, 0);

    wr(12'h100, 32'h5); rd(12'h100, d); chk("R1 set", d, 32'h5);
    wr(12'h100, 32'h0); rd(12'h100, d); chk("R1 zero no effect", d, 32'h5);
    wr(12'h100, 32'h2); rd(12'h100, d); chk("R1 accumulate", d, 32'h7);
    wr(12'h180, 32'h4); rd(12'h180, d); chk("R2 clear", d, 32'h3);
    wr(12'h180, 32'h0); rd(12'h100, d); chk("R2 zero no effect", d, 32'h3);

    wr(12'h200, 32'h20);
    chk("R7 disabled not reported", {22'd0, top_any, top_vec}, 0);
    rd(12'h200, d); chk("R3 setp readback", d, 32'h20);
    rd(12'h280, d); chk("R3 clrp readback", d, 32'h20);
    wr(12'h100, 32'h20);
    chk("R7 vector", {22'd0, top_any, top_vec}, {22'd0, 1'b1, 9'd21});
    wr(12'h280, 32'h20);
    chk("R3 clear pend", {22'd0, top_any, top_vec}, 0);

    wr(12'h100, 32'hFFFF_FFFF);
    for (int r = 0; r < 6; r++) begin
      wr(12'h280, 32'hFFFF_FFFF);
      wr(12'h400, TBL[r][72:41]);
      wr(12'h200, TBL[r][40:9]);
      chk($sformatf("R5 R6 R7 row %0d", r), {23'd0, top_vec}, {23'd0, TBL[r][8:0]});
      chk($sformatf("R7 any row %0d", r), {31'd0, top_any}, {31'd0, TBL[r][8:0] != 0});
    end

    wr(12'h404, 32'hFFFF_FFFF); rd(12'h404, d); chk("R4 field mask", d, 32'hC0C0_C0C0);
    wr(12'h280, 32'hFFFF_FFFF);
    wr(12'h200, 32'h0010_0040);
    chk("R5 urgent high line wins", {23'd0, top_vec}, 36);

    wr(12'h280, 32'hFFFF_FFFF);
    @(negedge clk); irq_in[9] = 1;
    @(negedge clk); #1;
    chk("R8 edge sets", {23'd0, top_vec}, 25);
    ack(9'd26); chk("R9 other vector no effect", {23'd0, top_vec}, 25);
    ack(9'd25); chk("R9 ack clears", {22'd0, top_any, top_vec}, 0);
    repeat (3) @(negedge clk); #1;
    chk("R8 held high no reset", {22'd0, top_any, top_vec}, 0);
    @(negedge clk); irq_in[9] = 0;
    @(negedge clk); irq_in[9] = 1;
    @(negedge clk); #1;
    chk("R8 second edge", {23'd0, top_vec}, 25);
    @(negedge clk); ack_valid = 1; ack_vec = 9'd25;
    reg_we = 1; reg_addr = 12'h200; reg_wdata = 32'h200;
    @(negedge clk); ack_valid = 0; reg_we = 0; #1;
    chk("R9 set beats ack", {23'd0, top_vec}, 25);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule